// File: doc/BRIEF.md
# Multiplier-Free Bit-Serial FIR Filter

This block is a fixed-coefficient finite impulse response filter that computes its dot product without any multiplier. Each accepted input sample enters a tap delay line. The filter then walks through the sample bits one bit position per clock, starting with the least significant bit. At each step it takes the selected bit from every tap. These bits form a set of small addresses, and each address reads a table that holds the sums of the coefficients whose taps show a one.

The table outputs are added, weighted by the power of two of the current bit position, and accumulated. The sign plane is subtracted, so two's complement samples are handled exactly. All tables are computed at elaboration from a coefficient parameter.

By default the filter has 32 taps and 8-bit samples. The taps are split into eight groups of four, and each group has its own 16-entry table. A result is ready eight clocks after its sample is accepted. When a new sample is offered on the final step of a computation, the filter accepts it there and starts the next computation with no gap. This gives one result every eight clocks.

Top module: `dafir_filter`

## Requirements
- R1: After a synchronous reset, `out_valid` and `out_data` are 0 and every delay-line stage holds 0, so the first result after reset is just the coefficient of tap 0 times the new sample.
- R2: Each result equals the sum over t = 0..TAPS-1 of coef[t] * x[n-t]. Tap 0 holds the sample just accepted, and coef[t] is the signed CW-bit field at `COEFS[t*CW +: CW]`.
- R3: Input samples are two's complement DW-bit values. The most negative value (-128 at DW = 8) and the other negative values are weighted with their correct sign.
- R4: `out_valid` is high for exactly one clock. It rises on the DW-th rising edge after the edge that accepted the sample, and `out_data` takes the new result on that same edge.
- R5: An `in_valid` that arrives while a computation is in progress, but not on its final step, is ignored: the offered sample never enters the delay line.
- R6: An `in_valid` on the final step of a computation is accepted. If `in_valid` is held high, one sample is taken and one result is delivered every DW clocks.
- R7: `out_data` keeps its value between `out_valid` pulses.
- R8: `out_data` is CW + log2(TAPS) + DW bits wide and carries the exact result without wrap, including when every tap holds the extreme sample value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Offers `in_sample`; taken when idle or on the final step |
| in_sample | input | DW | Two's complement input sample |
| out_valid | output | 1 | One-clock pulse when `out_data` holds a new result |
| out_data | output | CW+log2(TAPS)+DW | Two's complement filter result, registered |

## Verification
The bench drives impulses through every tap position. A design that mixed up tap order or table address bits would return coefficients in the wrong order. A sign-plane impulse and long runs of the extreme sample values target the subtracted top bit plane and the accumulator width. Getting the sign plane wrong flips or offsets results, and an undersized accumulator wraps. Samples poked in the middle of a computation, and a stream with `in_valid` held high, check the acceptance window. A design that takes samples too eagerly would corrupt later results, and one that misses the final-step slot would lose the one-result-per-eight-clocks rate.

// File: rtl/dafir_pkg.sv
package dafir_pkg;
  localparam int DEF_TAPS = 32;
  localparam int DEF_DW   = 8;
  localparam int DEF_CW   = 10;

  // Smooth, peaked default coefficient set, computed rather than listed.
  function automatic logic [DEF_TAPS*DEF_CW-1:0] default_coefs();
    logic [DEF_TAPS*DEF_CW-1:0] v;
    int c;
    v = '0;
    for (int t = 0; t < DEF_TAPS; t++) begin
      c = 300 - 2 * (t - 15) * (t - 15);
      v[t*DEF_CW +: DEF_CW] = c[DEF_CW-1:0];
    end
    return v;
  endfunction
endpackage

// File: rtl/dafir_taps.sv
module dafir_taps #(
  parameter int TAPS = 32,
  parameter int DW   = 8,
  localparam int BW  = (DW > 1) ? $clog2(DW) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [DW-1:0]   din,
  input  logic [BW-1:0]   bit_sel,
  input  logic            busy,
  input  logic            last,
  output logic [TAPS-1:0] plane
);
  logic [DW-1:0] stage [TAPS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int t = 0; t < TAPS; t++) stage[t] <= '0;
    end else if (load) begin
      stage[0] <= din;
      for (int t = 1; t < TAPS; t++) stage[t] <= stage[t-1];
    end
  end

  for (genvar t = 0; t < TAPS; t++) begin : g_plane
    assign plane[t] = stage[t][bit_sel];
  end

  // R5
  ignore_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !last) |=> $stable(stage[0]));
endmodule

// File: rtl/dafir_lut.sv
module dafir_lut #(
  parameter int GROUP = 4,
  parameter int CW    = 10,
  parameter int TW    = 12,
  parameter logic [GROUP*CW-1:0] COEF_G = '0,
  localparam int ENTRIES = 1 << GROUP
) (
  input  logic [GROUP-1:0] addr,
  output logic [TW-1:0]    q
);
  function automatic logic signed [TW-1:0] entry_sum(input int e);
    logic signed [TW-1:0] s;
    s = '0;
    for (int k = 0; k < GROUP; k++)
      if (e[k]) s = s + TW'($signed(COEF_G[k*CW +: CW]));
    return s;
  endfunction

  logic [TW-1:0] rom [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    localparam logic signed [TW-1:0] VAL = entry_sum(e);
    assign rom[e] = VAL;
  end

  assign q = rom[addr];
endmodule

// File: rtl/dafir_acc.sv
module dafir_acc #(
  parameter int DW   = 8,
  parameter int NGRP = 8,
  parameter int TW   = 12,
  parameter int OW   = 23,
  localparam int BW  = (DW > 1) ? $clog2(DW) : 1,
  localparam int SW  = TW + ((NGRP > 1) ? $clog2(NGRP) : 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [NGRP*TW-1:0] grp_q,
  output logic            load,
  output logic            busy,
  output logic            last,
  output logic [BW-1:0]   bit_sel,
  output logic            out_valid,
  output logic [OW-1:0]   out_data
);
  logic signed [SW-1:0] plane_sum;
  logic signed [OW-1:0] weighted, term, acc, acc_next;
  logic                 sign_step;

  always_comb begin
    plane_sum = '0;
    for (int g = 0; g < NGRP; g++)
      plane_sum = plane_sum + SW'($signed(grp_q[g*TW +: TW]));
  end

  assign sign_step = (bit_sel == BW'(DW-1));
  assign last      = busy && sign_step;
  assign load      = in_valid && (!busy || last);
  assign weighted  = OW'(plane_sum) <<< bit_sel;
  assign term      = sign_step ? -weighted : weighted;
  assign acc_next  = ((bit_sel == '0) ? '0 : acc) + term;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      bit_sel   <= '0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (busy) acc <= acc_next;
      if (last) begin
        out_data  <= acc_next;
        out_valid <= 1'b1;
      end
      if (load) begin
        busy    <= 1'b1;
        bit_sel <= '0;
      end else if (last) begin
        busy <= 1'b0;
      end else if (busy) begin
        bit_sel <= bit_sel + 1'b1;
      end
    end
  end

  // R4
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  // R7
  y_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data));
endmodule

// File: rtl/dafir_filter.sv
module dafir_filter import dafir_pkg::*; #(
  parameter int TAPS  = DEF_TAPS,
  parameter int DW    = DEF_DW,
  parameter int CW    = DEF_CW,
  parameter int GROUP = 4,
  parameter logic [TAPS*CW-1:0] COEFS = default_coefs(),
  localparam int OW   = CW + $clog2(TAPS) + DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_sample,
  output logic          out_valid,
  output logic [OW-1:0] out_data
);
  localparam int NGRP = TAPS / GROUP;
  localparam int TW   = CW + $clog2(GROUP);
  localparam int BW   = (DW > 1) ? $clog2(DW) : 1;

  logic              load, busy, last;
  logic [BW-1:0]     bit_sel;
  logic [TAPS-1:0]   plane;
  logic [NGRP*TW-1:0] grp_q;

  dafir_taps #(.TAPS(TAPS), .DW(DW)) u_taps (
    .clk(clk), .rst(rst), .load(load), .din(in_sample), .bit_sel(bit_sel),
    .busy(busy), .last(last), .plane(plane)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    dafir_lut #(
      .GROUP(GROUP), .CW(CW), .TW(TW),
      .COEF_G(COEFS[g*GROUP*CW +: GROUP*CW])
    ) u_lut (
      .addr(plane[g*GROUP +: GROUP]),
      .q(grp_q[g*TW +: TW])
    );
  end

  dafir_acc #(.DW(DW), .NGRP(NGRP), .TW(TW), .OW(OW)) u_acc (
    .clk(clk), .rst(rst), .in_valid(in_valid), .grp_q(grp_q),
    .load(load), .busy(busy), .last(last), .bit_sel(bit_sel),
    .out_valid(out_valid), .out_data(out_data)
  );

  logic [BW+1:0] since_load;
  always_ff @(posedge clk) begin
    if (rst) since_load <= '1;
    else if (load) since_load <= '0;
    else if (since_load != '1) since_load <= since_load + 1'b1;
  end

  // R4
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($past(since_load) == (BW+2)'(DW-1)));
  // R6
  back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
    (last && in_valid) |=> (busy && bit_sel == '0));
endmodule

// File: tb/dafir_filter_tb.sv
`timescale 1ns/1ps
module dafir_filter_tb_top;
  localparam int TAPS = 32;
  localparam int DW   = 8;
  localparam int CW   = 10;
  localparam int OW   = CW + $clog2(TAPS) + DW;

  function automatic int bcoef(input int t);
    return (t == 0) ? -512 : ((t * 97 + 31) % 1023) - 511;
  endfunction

  function automatic logic [TAPS*CW-1:0] build_coefs();
    logic [TAPS*CW-1:0] v;
    int c;
    v = '0;
    for (int t = 0; t < TAPS; t++) begin
      c = bcoef(t);
      v[t*CW +: CW] = c[CW-1:0];
    end
    return v;
  endfunction

  localparam logic [TAPS*CW-1:0] TB_COEFS = build_coefs();

  logic clk = 1'b0;
  logic rst;
  logic in_valid;
  logic [DW-1:0] in_sample;
  logic out_valid;
  logic [OW-1:0] out_data;

  always #10 clk = ~clk;

  dafir_filter #(.TAPS(TAPS), .DW(DW), .CW(CW), .GROUP(4), .COEFS(TB_COEFS)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_data(out_data)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  int hist [TAPS];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint yval();
    return longint'($signed(out_data));
  endfunction

  function automatic longint model_shift(input int v);
    longint s;
    for (int t = TAPS - 1; t > 0; t--) hist[t] = hist[t-1];
    hist[0] = v;
    s = 0;
    for (int t = 0; t < TAPS; t++) s += longint'(hist[t]) * longint'(bcoef(t));
    return s;
  endfunction

  // Offer one sample while idle; optionally poke in_valid at step poke_at.
  task automatic push_check(input int v, input string req, input int poke_at);
    longint e;
    @(negedge clk);
    in_valid = 1'b1; in_sample = v[DW-1:0];
    e = model_shift(v);
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 1; i <= 7; i++) begin
      if (i == poke_at) begin in_valid = 1'b1; in_sample = 8'd99; end
      @(negedge clk);
      in_valid = 1'b0;
    end
    check(out_valid == 1'b0, "R4 early", longint'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R4 pulse", longint'(out_valid), 1);
    check(yval() == e, req, yval(), e);
    @(negedge clk);
    check(out_valid == 1'b0, "R4 single", longint'(out_valid), 0);
    check(yval() == e, "R7 hold", yval(), e);
  endtask

  task automatic stream(input int n, inout int seed);
    longint pend, prev;
    int v;
    pend = 0; prev = 0;
    for (int m = 0; m < n; m++) begin
      for (int j = 0; j < DW; j++) begin
        if (j == 1 && m > 0) begin
          check(out_valid == 1'b1, "R6 rate", longint'(out_valid), 1);
          check(yval() == prev, "R6 value", yval(), prev);
        end else if (j >= 2) begin
          check(out_valid == 1'b0, "R5 busy", longint'(out_valid), 0);
        end
        seed = seed * 1103515245 + 12345;
        v = ((seed >>> 16) & 255) - 128;
        in_valid = 1'b1; in_sample = v[DW-1:0];
        if (j == 0) begin prev = pend; pend = model_shift(v); end
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b1, "R6 last", longint'(out_valid), 1);
    check(yval() == pend, "R6 last value", yval(), pend);
    repeat (2) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0; in_sample = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int t = 0; t < TAPS; t++) hist[t] = 0;
  endtask

  initial begin
    int seed;
    seed = 7;
    do_reset();
    check(out_valid == 1'b0, "R1 valid", longint'(out_valid), 0);
    check(yval() == 0, "R1 data", yval(), 0);

    // R2: impulse walks through every tap
    push_check(1, "R2 impulse", 0);
    for (int t = 1; t < TAPS + 2; t++) push_check(0, "R2 impulse", 0);

    // R3: sign plane impulse and mixed negatives
    push_check(-128, "R3 min", 0);
    for (int t = 1; t < 6; t++) push_check(0, "R3 min tail", 0);
    push_check(-1, "R3 neg", 0);
    push_check(-77, "R3 neg", 0);
    push_check(45, "R3 mix", 0);

    // R5: samples poked mid-computation must not enter
    push_check(12, "R5 poke", 3);
    push_check(-5, "R5 poke", 7);
    push_check(0, "R5 after", 1);

    // R8: extremes fill every tap
    for (int t = 0; t < TAPS; t++) push_check(-128, "R8 min", 0);
    for (int t = 0; t < TAPS; t++) push_check(127, "R8 max", 0);

    // R6: continuous offer
    stream(40, seed);

    // R1: reset in the middle of history
    do_reset();
    check(out_valid == 1'b0, "R1 valid", longint'(out_valid), 0);
    check(yval() == 0, "R1 data", yval(), 0);
    push_check(3, "R1 empty line", 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule